// File: doc/BRIEF.md
# Power Mode and Status Selector

This block turns a radio controller's settings word into power enables, mute lines and a battery-alarm setting for the analog sub-blocks around it. Each of the four sections (transmit RF, transmit audio, receive RF, receive audio) has its own power-save bit. The shared local oscillator stays on as long as at least one RF section is on. The two mute bits pass straight through to the compander and have no effect on the power state.

The block also drives an open-drain status pin from one of four internal flags: transmit lock, receive lock, a weak-signal comparator with hysteresis, and a noise comparator. A battery-alarm output, also open drain, compares a digitized battery level against one of four thresholds. The alarm filters out short dips and can be powered down by a bit that sits in the reference-divider register. The analog comparators are replaced by digital flags and level codes. Each open-drain pin is modelled as an output-enable: 1 pulls the pin low and 0 releases it.

Top module: `pwr_status_sel`

## Requirements
- R1: Settings bits 0..3 are the save bits for transmit RF, transmit audio, receive RF and receive audio. A save bit of 1 drives the matching enable (txRfEn, txAfEn, rxRfEn, rxAfEn) to 0, and a save bit of 0 drives it to 1. The bits are independent of each other.
- R2: oscEn is 0 only when both RF save bits (bits 0 and 2) are 1. Otherwise it is 1.
- R3: Bit 4 drives compMute and bit 5 drives expMute. Neither mute bit changes any enable.
- R4: Bits 6..9 select transmit lock, receive lock, weak signal and noise. When more than one is set, the priority order is bit 6, then 7, then 8, then 9. One clock after the inputs change, sigOe is 1 if the chosen flag is 0 and 0 if the chosen flag is 1.
- R5: When bits 6..9 are all 0, sigOe is 0 (pin released) one clock later, whatever the flags are.
- R6: A flag from a powered-down section reads as 0. Transmit lock reads 0 while bit 0 is 1. Receive lock, weak signal and noise read 0 while bit 2 is 1.
- R7: The weak-signal flag is set when rssiLvl is 72 or less and cleared when rssiLvl is 80 or more. Between those values it holds its state. It clears at reset. It reaches sigOe two clocks after rssiLvl changes.
- R8: Bits 11 and 10 form the threshold code {bit11, bit10}, which also appears on almThr. The codes 00, 01, 10 and 11 select batLvl thresholds of 300, 325, 330 and 345 (units of 10 mV). The battery counts as low when batLvl is strictly below the threshold.
- R9: With the alarm enabled, almOe rises on the 4th consecutive clock that sees a low battery. It falls on the 4th consecutive clock that sees a battery that is not low. A shorter run leaves almOe unchanged.
- R10: refBat = 1 powers the alarm down. almEn is then 0, almOe is 0, and the filter count is cleared.
- R11: After reset, sigOe and almOe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctrlWord | input | 12 | Settings word (saves, mutes, status select, threshold code) |
| refBat | input | 1 | Alarm power-save bit taken from the reference register |
| txLock | input | 1 | Transmit synthesizer lock flag |
| rxLock | input | 1 | Receive synthesizer lock flag |
| noiseHigh | input | 1 | Noise comparator result |
| rssiLvl | input | 8 | Digitized signal-strength level, 10 mV units |
| batLvl | input | 9 | Digitized battery level, 10 mV units |
| txRfEn | output | 1 | Transmit RF section enable |
| txAfEn | output | 1 | Transmit audio section enable |
| rxRfEn | output | 1 | Receive RF section enable |
| rxAfEn | output | 1 | Receive audio section enable |
| oscEn | output | 1 | Shared local oscillator enable |
| compMute | output | 1 | Compressor output mute |
| expMute | output | 1 | Expander output mute |
| almEn | output | 1 | Battery-alarm block enable |
| almThr | output | 2 | Selected threshold code |
| sigOe | output | 1 | Status pin pull-low enable |
| almOe | output | 1 | Alarm pin pull-low enable |

## Verification
Two functions can act on the same edge. One is a status-select change whose effect on sigOe is delayed by a power-save bit that forces the chosen flag to 0. The other is a weak-signal hysteresis update that lands on the same edge as the select change. The random phase changes the settings word, the flags and rssiLvl together. A bench model that tracks the hysteresis state on its own predicts sigOe, and sigOe is compared after the two-clock settling time. The alarm filter runs at the same time as status-pin changes, so the directed alarm runs also check that the status pin holds while the count advances.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int CTRL_W   = 12;
  localparam int CW_TXRF  = 0;
  localparam int CW_TXAF  = 1;
  localparam int CW_RXRF  = 2;
  localparam int CW_RXAF  = 3;
  localparam int CW_CMUTE = 4;
  localparam int CW_EMUTE = 5;
  localparam int CW_SELTX = 6;
  localparam int CW_SELRX = 7;
  localparam int CW_SELWK = 8;
  localparam int CW_SELNS = 9;
  localparam int CW_THRLO = 10;
  localparam int CW_THRHI = 11;

  typedef struct packed {
    logic       txRfOn;
    logic       txAfOn;
    logic       rxRfOn;
    logic       rxAfOn;
    logic       oscOn;
    logic       compMute;
    logic       expMute;
    logic       almOn;
    logic       useLock;
    logic       useDet;
    logic       pickTx;
    logic       pickWeak;
    logic [1:0] thrSel;
  } pssStrobe_t;
endpackage

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              refBat,
  output pssStrobe_t        strb
);
  logic selTx, selRx, selWk, selNs;

  assign selTx = ctrlWord[CW_SELTX];
  assign selRx = ctrlWord[CW_SELRX];
  assign selWk = ctrlWord[CW_SELWK];
  assign selNs = ctrlWord[CW_SELNS];

  always_comb begin
    strb.txRfOn   = ~ctrlWord[CW_TXRF];
    strb.txAfOn   = ~ctrlWord[CW_TXAF];
    strb.rxRfOn   = ~ctrlWord[CW_RXRF];
    strb.rxAfOn   = ~ctrlWord[CW_RXAF];
    strb.oscOn    = ~(ctrlWord[CW_TXRF] & ctrlWord[CW_RXRF]);
    strb.compMute = ctrlWord[CW_CMUTE];
    strb.expMute  = ctrlWord[CW_EMUTE];
    strb.almOn    = ~refBat;
    // first switch: lock detectors, transmit wins
    strb.useLock  = selTx | selRx;
    strb.pickTx   = selTx;
    // second switch: detector outputs, only when no lock source is asked for
    strb.useDet   = ~(selTx | selRx) & (selWk | selNs);
    strb.pickWeak = selWk;
    strb.thrSel   = {ctrlWord[CW_THRHI], ctrlWord[CW_THRLO]};
  end

  // R4: at most one of the two switch paths reaches the pin
  a_r4_one_path: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.useLock, strb.useDet}));

  // R2: oscillator is off only with both RF sections in save
  a_r2_osc_dep: assert property (@(posedge clk) disable iff (!rstN)
    !strb.oscOn |-> (!strb.txRfOn && !strb.rxRfOn));
endmodule

// File: rtl/pss_datapath.sv
module pss_datapath
  import pss_pkg::*;
#(
  parameter int LVL_W    = 8,
  parameter int BAT_W    = 9,
  parameter int WEAK_SET = 72,
  parameter int WEAK_CLR = 80,
  parameter int THR0     = 300,
  parameter int THR1     = 325,
  parameter int THR2     = 330,
  parameter int THR3     = 345,
  parameter int FILT_LEN = 4
)(
  input  logic             clk,
  input  logic             rstN,
  input  pssStrobe_t       strb,
  input  logic             txLock,
  input  logic             rxLock,
  input  logic             noiseHigh,
  input  logic [LVL_W-1:0] rssiLvl,
  input  logic [BAT_W-1:0] batLvl,
  output logic             sigOe,
  output logic             almOe
);
  localparam int CNT_W = $clog2(FILT_LEN) + 1;
  localparam int NTHR  = 4;
  localparam logic [NTHR*BAT_W-1:0] THR_TAB =
    {BAT_W'(THR3), BAT_W'(THR2), BAT_W'(THR1), BAT_W'(THR0)};

  logic             weakSig;
  logic             txG, rxG, wkG, nsG, lockFlag, detFlag, chosen, sigNext;
  logic [BAT_W-1:0] thrVal;
  logic             batLow;
  logic [CNT_W-1:0] runCnt;

  // weak-signal comparator with hysteresis
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                weakSig <= 1'b0;
    else if (rssiLvl <= LVL_W'(WEAK_SET))     weakSig <= 1'b1;
    else if (rssiLvl >= LVL_W'(WEAK_CLR))     weakSig <= 1'b0;
  end

  // flags of a powered-down section read as 0
  assign txG = txLock    & strb.txRfOn;
  assign rxG = rxLock    & strb.rxRfOn;
  assign wkG = weakSig   & strb.rxRfOn;
  assign nsG = noiseHigh & strb.rxRfOn;

  assign lockFlag = strb.pickTx   ? txG : rxG;
  assign detFlag  = strb.pickWeak ? wkG : nsG;
  assign chosen   = strb.useLock  ? lockFlag : detFlag;
  assign sigNext  = (strb.useLock | strb.useDet) & ~chosen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sigOe <= 1'b0;
    else       sigOe <= sigNext;
  end

  // threshold lookup
  always_comb begin
    thrVal = '0;
    for (int i = 0; i < NTHR; i++)
      if (strb.thrSel == 2'(i)) thrVal = THR_TAB[i*BAT_W +: BAT_W];
  end
  assign batLow = batLvl < thrVal;

  // run-length filter on the alarm
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      almOe  <= 1'b0;
      runCnt <= '0;
    end else if (!strb.almOn) begin
      almOe  <= 1'b0;
      runCnt <= '0;
    end else if (batLow != almOe) begin
      if (runCnt == CNT_W'(FILT_LEN - 1)) begin
        almOe  <= batLow;
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end else begin
      runCnt <= '0;
    end
  end

  // R5: no select bit releases the pin on the next edge
  a_r5_release: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.useLock && !strb.useDet) |=> !sigOe);

  // R7: inside the hysteresis window the comparator holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rssiLvl > LVL_W'(WEAK_SET) && rssiLvl < LVL_W'(WEAK_CLR)) |=> $stable(weakSig));

  // R10: alarm in save keeps the pin released
  a_r10_alm_off: assert property (@(posedge clk) disable iff (!rstN)
    !strb.almOn |=> !almOe);

  // R9: the alarm only toggles once the run count is complete
  a_r9_filter: assert property (@(posedge clk) disable iff (!rstN)
    (strb.almOn && almOe != batLow && runCnt != CNT_W'(FILT_LEN - 1)) |=> $stable(almOe));

  // R6: a powered-down receive section cannot release the pin via the weak path
  a_r6_rx_gate: assert property (@(posedge clk) disable iff (!rstN)
    (strb.useDet && strb.pickWeak && !strb.rxRfOn) |=> sigOe);
endmodule

// File: rtl/pwr_status_sel.sv
module pwr_status_sel
  import pss_pkg::*;
#(
  parameter int LVL_W    = 8,
  parameter int BAT_W    = 9,
  parameter int FILT_LEN = 4
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              refBat,
  input  logic              txLock,
  input  logic              rxLock,
  input  logic              noiseHigh,
  input  logic [LVL_W-1:0]  rssiLvl,
  input  logic [BAT_W-1:0]  batLvl,
  output logic              txRfEn,
  output logic              txAfEn,
  output logic              rxRfEn,
  output logic              rxAfEn,
  output logic              oscEn,
  output logic              compMute,
  output logic              expMute,
  output logic              almEn,
  output logic [1:0]        almThr,
  output logic              sigOe,
  output logic              almOe
);
  pssStrobe_t strb;

  pss_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWord (ctrlWord),
    .refBat   (refBat),
    .strb     (strb)
  );

  pss_datapath #(
    .LVL_W    (LVL_W),
    .BAT_W    (BAT_W),
    .FILT_LEN (FILT_LEN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .txLock    (txLock),
    .rxLock    (rxLock),
    .noiseHigh (noiseHigh),
    .rssiLvl   (rssiLvl),
    .batLvl    (batLvl),
    .sigOe     (sigOe),
    .almOe     (almOe)
  );

  assign txRfEn   = strb.txRfOn;
  assign txAfEn   = strb.txAfOn;
  assign rxRfEn   = strb.rxRfOn;
  assign rxAfEn   = strb.rxAfOn;
  assign oscEn    = strb.oscOn;
  assign compMute = strb.compMute;
  assign expMute  = strb.expMute;
  assign almEn    = strb.almOn;
  assign almThr   = strb.thrSel;
endmodule

// File: tb/pwr_status_sel_test.sv
module pwr_status_sel_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] ctrlWord = '0;
  logic        refBat = 1'b0;
  logic        txLock = 1'b0, rxLock = 1'b0, noiseHigh = 1'b0;
  logic [7:0]  rssiLvl = 8'd200;
  logic [8:0]  batLvl = 9'd400;
  logic        txRfEn, txAfEn, rxRfEn, rxAfEn, oscEn, compMute, expMute, almEn;
  logic [1:0]  almThr;
  logic        sigOe, almOe;

  int nChk = 0, nBad = 0;
  bit finished = 0;
  bit weakM = 0;

  always #2 clk = ~clk;

  pwr_status_sel uut (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .refBat(refBat),
    .txLock(txLock), .rxLock(rxLock), .noiseHigh(noiseHigh),
    .rssiLvl(rssiLvl), .batLvl(batLvl),
    .txRfEn(txRfEn), .txAfEn(txAfEn), .rxRfEn(rxRfEn), .rxAfEn(rxAfEn),
    .oscEn(oscEn), .compMute(compMute), .expMute(expMute), .almEn(almEn),
    .almThr(almThr), .sigOe(sigOe), .almOe(almOe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected enables/mutes vector: {txRf,txAf,rxRf,rxAf,osc,cMute,eMute,almEn,thr[1:0]}
  function automatic logic [9:0] expEn(input logic [11:0] cw, input logic bc);
    return {~cw[0], ~cw[1], ~cw[2], ~cw[3], ~(cw[0] & cw[2]), cw[4], cw[5], ~bc, cw[11], cw[10]};
  endfunction

  function automatic logic expSig(input logic [11:0] cw, input logic tl, input logic rl,
                                  input logic wk, input logic ns);
    logic t, r, w, n;
    t = tl & ~cw[0];
    r = rl & ~cw[2];
    w = wk & ~cw[2];
    n = ns & ~cw[2];
    if (cw[6]) return ~t;
    if (cw[7]) return ~r;
    if (cw[8]) return ~w;
    if (cw[9]) return ~n;
    return 1'b0;
  endfunction

  function automatic bit weakNext(input bit cur, input logic [7:0] lvl);
    if (lvl <= 8'd72) return 1'b1;
    if (lvl >= 8'd80) return 1'b0;
    return cur;
  endfunction

  task automatic applySig(input logic [11:0] cw, input logic tl, input logic rl,
                          input logic ns, input logic [7:0] lvl, input string req);
    ctrlWord = cw; txLock = tl; rxLock = rl; noiseHigh = ns; rssiLvl = lvl;
    weakM = weakNext(weakM, lvl);
    step(3);
    check(req, {15'd0, sigOe}, {15'd0, expSig(cw, tl, rl, weakM, ns)});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    step(2);
    // R11: reset state
    check("R11 sigOe", {15'd0, sigOe}, 16'd0);
    check("R11 almOe", {15'd0, almOe}, 16'd0);
    rstN = 1'b1;
    step(2);

    // R1/R2/R3 directed corners
    ctrlWord = 12'h005; step(1);
    check("R2 both RF saved", {6'd0, txRfEn, txAfEn, rxRfEn, rxAfEn, oscEn, compMute, expMute, almEn, almThr},
          {6'd0, expEn(12'h005, 1'b0)});
    check("R2 osc off", {15'd0, oscEn}, 16'd0);
    ctrlWord = 12'h001; step(1);
    check("R2 one RF saved", {15'd0, oscEn}, 16'd1);
    ctrlWord = 12'h030; step(1);
    check("R3 mutes no power effect", {6'd0, txRfEn, txAfEn, rxRfEn, rxAfEn, oscEn, compMute, expMute, almEn, almThr},
          {6'd0, 10'b1111111100});
    ctrlWord = 12'h00A; step(1);
    check("R1 audio saves", {12'd0, txRfEn, txAfEn, rxRfEn, rxAfEn}, {12'd0, 4'b1010});

    // R4 single selects and priority, R5 release, R6 gating
    applySig(12'h040, 1'b0, 1'b1, 1'b1, 8'd200, "R4 tx lock pattern 1000");
    applySig(12'h0C0, 1'b1, 1'b0, 1'b0, 8'd200, "R4 tx over rx");
    applySig(12'h180, 1'b1, 1'b0, 1'b1, 8'd200, "R4 rx over weak");
    applySig(12'h300, 1'b0, 1'b0, 1'b1, 8'd50,  "R4 weak over noise");
    applySig(12'h200, 1'b0, 1'b0, 1'b0, 8'd50,  "R4 noise only");
    applySig(12'h000, 1'b0, 1'b0, 1'b0, 8'd50,  "R5 no select released");
    applySig(12'h041, 1'b1, 1'b1, 1'b1, 8'd50,  "R6 tx lock gated");
    applySig(12'h204, 1'b1, 1'b1, 1'b1, 8'd50,  "R6 noise gated");

    // R7 hysteresis walk on weak-signal path
    applySig(12'h100, 1'b0, 1'b0, 1'b0, 8'd79, "R7 hold set at 79");
    applySig(12'h100, 1'b0, 1'b0, 1'b0, 8'd80, "R7 clear at 80");
    applySig(12'h100, 1'b0, 1'b0, 1'b0, 8'd73, "R7 hold clear at 73");
    applySig(12'h100, 1'b0, 1'b0, 1'b0, 8'd72, "R7 set at 72");

    // random phase
    for (int i = 0; i < 300; i++) begin
      logic [11:0] cw;
      logic [7:0]  lv;
      logic        bc;
      cw = 12'($urandom);
      bc = 1'($urandom);
      case ($urandom % 4)
        0: lv = 8'd72;
        1: lv = 8'd80;
        2: lv = 8'(70 + $urandom % 12);
        default: lv = 8'($urandom);
      endcase
      refBat = bc;
      applySig(cw, 1'($urandom), 1'($urandom), 1'($urandom), lv, "R4 random status");
      check("R1 random enables", {6'd0, txRfEn, txAfEn, rxRfEn, rxAfEn, oscEn, compMute, expMute, almEn, almThr},
            {6'd0, expEn(cw, bc)});
      check("R10 random alarm idle", {15'd0, almOe}, 16'd0);
    end

    // R8/R9 alarm directed
    refBat = 1'b0; ctrlWord = 12'h040; txLock = 1'b1; batLvl = 9'd300;
    step(6);
    check("R8 equal threshold not low", {15'd0, almOe}, 16'd0);
    batLvl = 9'd299; step(3);
    check("R9 three low samples", {15'd0, almOe}, 16'd0);
    check("R9 status held during count", {15'd0, sigOe}, 16'd0);
    step(1);
    check("R9 fourth low sample", {15'd0, almOe}, 16'd1);
    batLvl = 9'd301; step(2);
    batLvl = 9'd299; step(2);
    check("R9 short recovery ignored", {15'd0, almOe}, 16'd1);
    batLvl = 9'd320; step(4);
    check("R9 four recovery samples", {15'd0, almOe}, 16'd0);
    ctrlWord = 12'hC40; batLvl = 9'd344; step(1);
    check("R8 thr code out", {14'd0, almThr}, 16'd3);
    step(3);
    check("R8 code 11 at 344", {15'd0, almOe}, 16'd1);
    ctrlWord = 12'h440; step(6);
    check("R8 code 01 at 344", {15'd0, almOe}, 16'd0);
    ctrlWord = 12'h840; batLvl = 9'd329; step(4);
    check("R8 code 10 at 329", {15'd0, almOe}, 16'd1);
    refBat = 1'b1; step(1);
    check("R10 alarm saved", {14'd0, almEn, almOe}, 16'd0);
    refBat = 1'b0; step(3);
    check("R10 count cleared", {15'd0, almOe}, 16'd0);
    step(1);
    check("R10 restart after four", {15'd0, almOe}, 16'd1);

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      nChk++; nBad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end
endmodule